// File: doc/BRIEF.md
# Densely Packed Decimal Codec

This block converts between three-digit binary coded decimal (12 bits, hundreds digit in the top nibble) and a 10-bit densely packed decimal declet. It has two independent paths. The encoder packs a BCD triple and raises a flag when any of its nibbles is not a decimal digit. The decoder expands any of the 1024 possible declets into a valid BCD triple.

Each digit is classed as small (0 to 7) or large (8 or 9). Three indicator bits in the low half of the declet say which digits are large. As a result, a number whose digits are all small has the same low bits as its BCD form. Any value from 0 to 79 encodes to exactly its BCD pattern, so short numbers padded with leading zeros need no separate handling.

A parameter selects a register stage on all outputs, which has a synchronous active-high reset. The alternative is purely combinational paths.

Top module: `dpd_codec`

## Requirements
Declet bits are named, from bit 9 down to bit 0: p q r s t u v w x y. The hundreds digit is abcd (bits 11..8), the tens digit is efgh (bits 7..4) and the units digit is ijkm (bits 3..0). A digit is large when its top bit is 1.
- R1: The lowest bit of each digit always passes straight through: d goes to r (bit 7), h goes to u (bit 4) and m goes to y (bit 0).
- R2: When all three digits are small, v (bit 3) is 0 and the declet is b c d f g h 0 j k m. When any digit is large, v is 1.
- R3: With exactly one large digit, the declet is as follows. Large units give b c d f g h 1 0 0 m. Large tens give b c d j k h 1 0 1 m. A large hundreds digit gives j k d f g h 1 1 0 m.
- R4: With two or three large digits, v w x is 111 and s t picks the case. Large tens and units give b c d 1 0 h 1 1 1 m. Large hundreds and units give f g d 0 1 h 1 1 1 m. Large hundreds and tens give j k d 0 0 h 1 1 1 m. All three large gives 0 0 d 1 1 h 1 1 1 m.
- R5: Every value from 0 to 79 encodes to the same 10-bit pattern as its BCD form (for example 77 gives 0x077).
- R6: Decoding the encoding of any of the 1000 valid triples returns the original triple.
- R7: Every one of the 1024 declets decodes to three nibbles, each no greater than 9. When v, w, x, s and t are all 1, p and q are ignored. The 24 such declets with p q not 00 decode like the same declet with p q = 00.
- R8: The encoder's invalid flag is 1 exactly when at least one input nibble exceeds 9.
- R9: With the register stage enabled (the default), each output reflects the inputs sampled at the previous rising clock edge. A clock edge with reset high clears all outputs to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset of the output register |
| enc_bcd_i | input | 12 | BCD triple to encode, hundreds digit in bits 11..8 |
| enc_dpd_o | output | 10 | Encoded declet |
| enc_bad_o | output | 1 | Some encoder input nibble is above 9 |
| dec_dpd_i | input | 10 | Declet to decode |
| dec_bcd_o | output | 12 | Decoded BCD triple |

## Verification
The codec holds no state beyond the output register. A faulty case mapping therefore shows up at the ports one clock after the offending input: a misplaced bit, a wrong indicator pattern or an out-of-range nibble. The exhaustive sweeps reach every digit-class combination on the encoder and every declet on the decoder, so no mapping error can stay hidden. A faulty register stage shows up as a wrong reset value or as an output that changes in the wrong cycle.

// File: rtl/dpd_pkg.sv
`timescale 1ns/1ps
package dpd_pkg;
  localparam int DIGIT_W    = 4;
  localparam int NUM_DIGITS = 3;
  localparam int BCD_W      = DIGIT_W * NUM_DIGITS;
  localparam int DECLET_W   = 10;
  localparam int MAX_DIGIT  = 9;

  typedef logic [BCD_W-1:0]    bcd3_t;
  typedef logic [DECLET_W-1:0] declet_t;
  typedef logic [DIGIT_W-1:0]  nib_t;
endpackage

// File: rtl/dpd_digit_class.sv
`timescale 1ns/1ps
module dpd_digit_class
  import dpd_pkg::*;
(
  input  nib_t nib_i,
  output logic large_o,
  output logic bad_o
);
  // large: 8..15 by top bit; only 8 and 9 are legal decimal
  assign large_o = nib_i[DIGIT_W-1];
  assign bad_o   = (nib_i > nib_t'(MAX_DIGIT));
endmodule

// File: rtl/dpd_enc.sv
`timescale 1ns/1ps
module dpd_enc
  import dpd_pkg::*;
(
  input  bcd3_t   bcd_i,
  output declet_t dpd_o,
  output logic    bad_o
);
  logic [NUM_DIGITS-1:0] big;
  logic [NUM_DIGITS-1:0] bad;

  for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_cls
    dpd_digit_class u_cls (
      .nib_i  (bcd_i[g*DIGIT_W +: DIGIT_W]),
      .large_o(big[g]),
      .bad_o  (bad[g])
    );
  end

  logic b, c, d, f, g, h, j, k, m;
  always_comb begin
    {b, c, d} = bcd_i[10:8];
    {f, g, h} = bcd_i[6:4];
    {j, k, m} = bcd_i[2:0];
    unique case (big) // {hundreds, tens, units}
      3'b000:  dpd_o = {b, c, d, f, g, h, 1'b0, j, k, m};
      3'b001:  dpd_o = {b, c, d, f, g, h, 3'b100, m};
      3'b010:  dpd_o = {b, c, d, j, k, h, 3'b101, m};
      3'b100:  dpd_o = {j, k, d, f, g, h, 3'b110, m};
      3'b011:  dpd_o = {b, c, d, 2'b10, h, 3'b111, m};
      3'b101:  dpd_o = {f, g, d, 2'b01, h, 3'b111, m};
      3'b110:  dpd_o = {j, k, d, 2'b00, h, 3'b111, m};
      default: dpd_o = {2'b00, d, 2'b11, h, 3'b111, m};
    endcase
    bad_o = |bad;
  end
endmodule

// File: rtl/dpd_dec.sv
`timescale 1ns/1ps
module dpd_dec
  import dpd_pkg::*;
(
  input  declet_t dpd_i,
  output bcd3_t   bcd_o
);
  logic p, q, r, s, t, u, v, w, x, y;
  nib_t hun, ten, uni;

  always_comb begin
    {p, q, r, s, t, u, v, w, x, y} = dpd_i;
    hun = {1'b0, p, q, r};
    ten = {1'b0, s, t, u};
    uni = {1'b0, w, x, y};
    if (v) begin
      unique case ({w, x})
        2'b00: uni = {3'b100, y};
        2'b01: begin ten = {3'b100, u}; uni = {1'b0, s, t, y}; end
        2'b10: begin hun = {3'b100, r}; uni = {1'b0, p, q, y}; end
        default: begin
          unique case ({s, t})
            2'b00: begin hun = {3'b100, r}; ten = {3'b100, u}; uni = {1'b0, p, q, y}; end
            2'b01: begin hun = {3'b100, r}; ten = {1'b0, p, q, u}; uni = {3'b100, y}; end
            2'b10: begin ten = {3'b100, u}; uni = {3'b100, y}; end
            default: begin hun = {3'b100, r}; ten = {3'b100, u}; uni = {3'b100, y}; end
          endcase
        end
      endcase
    end
    bcd_o = {hun, ten, uni};
  end
endmodule

// File: rtl/dpd_codec.sv
`timescale 1ns/1ps
module dpd_codec
  import dpd_pkg::*;
#(
  parameter bit PIPE = 1'b1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [BCD_W-1:0]    enc_bcd_i,
  output logic [DECLET_W-1:0] enc_dpd_o,
  output logic                enc_bad_o,
  input  logic [DECLET_W-1:0] dec_dpd_i,
  output logic [BCD_W-1:0]    dec_bcd_o
);
  declet_t enc_w;
  logic    bad_w;
  bcd3_t   dec_w;

  dpd_enc u_enc (.bcd_i(enc_bcd_i), .dpd_o(enc_w), .bad_o(bad_w));
  dpd_dec u_dec (.dpd_i(dec_dpd_i), .bcd_o(dec_w));

  if (PIPE) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        enc_dpd_o <= '0;
        enc_bad_o <= 1'b0;
        dec_bcd_o <= '0;
      end else begin
        enc_dpd_o <= enc_w;
        enc_bad_o <= bad_w;
        dec_bcd_o <= dec_w;
      end
    end

    AST_RESET_CLEARS: assert property (@(posedge clk) $past(rst) |-> (enc_dpd_o == '0 && dec_bcd_o == '0 && !enc_bad_o)); // R9
  end else begin : g_comb
    assign enc_dpd_o = enc_w;
    assign enc_bad_o = bad_w;
    assign dec_bcd_o = dec_w;
  end

  AST_LOW_BITS_PASS: assert property (@(posedge clk) disable iff (rst)
    (enc_w[7] == enc_bcd_i[8] && enc_w[4] == enc_bcd_i[4] && enc_w[0] == enc_bcd_i[0])); // R1
  AST_ALL_SMALL_V: assert property (@(posedge clk) disable iff (rst)
    (enc_w[3] == (enc_bcd_i[11] | enc_bcd_i[7] | enc_bcd_i[3]))); // R2
  AST_BAD_ONLY_OVER9: assert property (@(posedge clk) disable iff (rst)
    bad_w |-> (enc_bcd_i[11:8] > 4'd9 || enc_bcd_i[7:4] > 4'd9 || enc_bcd_i[3:0] > 4'd9)); // R8
  AST_DEC_DIGITS_OK: assert property (@(posedge clk) disable iff (rst)
    (dec_w[11:8] <= 4'd9 && dec_w[7:4] <= 4'd9 && dec_w[3:0] <= 4'd9)); // R7
  AST_DEC_LOW_PASS: assert property (@(posedge clk) disable iff (rst)
    (dec_w[8] == dec_dpd_i[7] && dec_w[4] == dec_dpd_i[4] && dec_w[0] == dec_dpd_i[0])); // R1
endmodule

// File: tb/sim_dpd_codec.sv
`timescale 1ns/1ps
module sim_dpd_codec;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] enc_bcd_i = '0;
  logic [9:0]  dec_dpd_i = '0;
  logic [9:0]  enc_dpd_o;
  logic        enc_bad_o;
  logic [11:0] dec_bcd_o;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  dpd_codec u0 (
    .clk(clk), .rst(rst),
    .enc_bcd_i(enc_bcd_i), .enc_dpd_o(enc_dpd_o), .enc_bad_o(enc_bad_o),
    .dec_dpd_i(dec_dpd_i), .dec_bcd_o(dec_bcd_o)
  );

  // {bcd triple, expected declet}
  localparam logic [21:0] VEC [0:12] = '{
    {12'h000, 10'h000}, {12'h007, 10'h007}, {12'h077, 10'h077},
    {12'h079, 10'h079}, {12'h123, 10'h0A3}, {12'h777, 10'h3F7},
    {12'h579, 10'h2F9}, {12'h786, 10'h3EA}, {12'h800, 10'h00C},
    {12'h099, 10'h05F}, {12'h908, 10'h0AE}, {12'h980, 10'h08E},
    {12'h999, 10'h0FF}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one rising edge, then sample 1 ns later
  task automatic step();
    @(posedge clk);
    #1;
  endtask

  function automatic logic [11:0] to_bcd(input int n);
    return {4'(n / 100), 4'((n / 10) % 10), 4'(n % 10)};
  endfunction

  initial begin
    #(200000 * 5);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=%h expected=%h", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    enc_bcd_i = 12'h999;
    dec_dpd_i = 10'h3FF;
    step();
    step();
    // R9 reset clears outputs even with nonzero inputs
    chk(enc_dpd_o == 10'h000 && dec_bcd_o == 12'h000 && !enc_bad_o, "R9 reset",
        {enc_bad_o, enc_dpd_o, dec_bcd_o}, 0);
    rst = 1'b0;

    // table walk: R3/R4 mappings in both directions
    foreach (VEC[i]) begin
      enc_bcd_i = VEC[i][21:10];
      dec_dpd_i = VEC[i][9:0];
      step();
      chk(enc_dpd_o == VEC[i][9:0], "R3/R4 encode", enc_dpd_o, VEC[i][9:0]);
      chk(dec_bcd_o == VEC[i][21:10], "R6 decode", dec_bcd_o, VEC[i][21:10]);
    end

    // R9 latency: new input shows only after the next edge
    enc_bcd_i = 12'h007;
    step();
    enc_bcd_i = 12'h077;
    #1;
    chk(enc_dpd_o == 10'h007, "R9 holds until edge", enc_dpd_o, 10'h007);
    step();
    chk(enc_dpd_o == 10'h077, "R9 updates after edge", enc_dpd_o, 10'h077);

    // R8 invalid flag
    enc_bcd_i = 12'hA00; step();
    chk(enc_bad_o == 1'b1, "R8 hundreds A", enc_bad_o, 1);
    enc_bcd_i = 12'h0F0; step();
    chk(enc_bad_o == 1'b1, "R8 tens F", enc_bad_o, 1);
    enc_bcd_i = 12'h00B; step();
    chk(enc_bad_o == 1'b1, "R8 units B", enc_bad_o, 1);
    enc_bcd_i = 12'h989; step();
    chk(enc_bad_o == 1'b0, "R8 valid large", enc_bad_o, 0);

    // exhaustive round trip over valid triples
    for (int n = 0; n < 1000; n++) begin
      logic [11:0] b;
      logic [9:0]  dl;
      logic        any_big;
      b = to_bcd(n);
      any_big = b[11] | b[7] | b[3];
      enc_bcd_i = b;
      step();
      dl = enc_dpd_o;
      chk(!enc_bad_o, "R8 no flag on valid", enc_bad_o, 0);
      chk(dl[7] == b[8] && dl[4] == b[4] && dl[0] == b[0], "R1 low bits", dl, b);
      chk(dl[3] == any_big, "R2 indicator v", dl[3], any_big);
      if (n < 80) chk(dl == b[9:0], "R5 short value equals BCD", dl, b);
      dec_dpd_i = dl;
      step();
      chk(dec_bcd_o == b, "R6 round trip", dec_bcd_o, b);
    end

    // every declet through the decoder, then re-encoded
    for (int d = 0; d < 1024; d++) begin
      logic [9:0]  dl;
      logic [9:0]  exp;
      logic [11:0] got;
      dl = 10'(d);
      dec_dpd_i = dl;
      step();
      got = dec_bcd_o;
      chk(got[11:8] <= 4'd9 && got[7:4] <= 4'd9 && got[3:0] <= 4'd9, "R7 valid digits", got, 12'h999);
      // pq ignored when v w x s t all one
      exp = (dl[3:1] == 3'b111 && dl[6:5] == 2'b11) ? (dl & 10'h0FF) : dl;
      enc_bcd_i = got;
      step();
      chk(enc_dpd_o == exp, "R7 canonical re-encode", enc_dpd_o, exp);
    end

    // R9 reset during operation
    enc_bcd_i = 12'h555;
    dec_dpd_i = 10'h155;
    rst = 1'b1;
    step();
    chk(enc_dpd_o == 0 && dec_bcd_o == 0, "R9 reset mid-run", {enc_dpd_o, dec_bcd_o}, 0);
    rst = 1'b0;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule